// File: doc/BRIEF.md
# Multi-Channel Debounced Interrupt Detector

This block watches up to eight asynchronous external lines and turns each settled change of level into one interrupt event. Every line passes through a two-flop synchronizer and then through its own debounce counter. The counter runs in whole milliseconds, and the period is programmable per channel from 1 to 4000 ms. A shared prescaler divides the system clock down to a one-millisecond tick. The prescaler and all counters advance only while a registered activity flag is high, so the timing logic is idle whenever no enabled channel has anything to qualify.

Each channel has its own configuration word. The word holds the period, an active-low polarity select, an enable bit and a mask bit. A qualified transition to the active level sets a sticky status bit, and software clears that bit by writing 1 to it. The single interrupt output is the registered OR of every status bit that is enabled and unmasked. Software reaches the block through a plain register port. A read returns its data one cycle after the read strobe.

Top module: `irq_debounce_hub`

## Requirements
- R1: Each channel filters its own line independently. A settled level on one channel never changes the stable level or status of another channel. Stable levels read at address 8, with bit i for channel i.
- R2: With period P (configuration bits [11:0], 1..4000), a new level is accepted only after it has held through P full tick intervals. It is accepted no later than P+1 tick intervals plus a few cycles after the input changed.
- R3: A pulse shorter than one tick interval never changes the stable level and never sets status.
- R4: A transition to the active level produces exactly one event. Holding the new level produces no further event. A qualified return to the inactive level updates the stable level without an event.
- R5: Configuration bit 12 selects the polarity: 0 makes high the active level, 1 makes low the active level.
- R6: The interrupt output is high, one register stage later, exactly while some status bit has enable (bit 13) set and mask (bit 14) clear. Address 10 reads that same pending set.
- R7: Status bits (address 9) are sticky. A write to address 9 clears each bit that is written as 1, and no other event clears a status bit.
- R8: A change of the synchronized input before the count expires reloads the counter, and the stored stable level stays as it was.
- R9: `gate_open` is high one cycle after some enabled channel either has an input that differs from its stable level or has a running counter. It is low when no channel is in that state, and the tick and all counters stop while it is low.
- R10: A disabled channel raises no event and keeps `gate_open` low. Its stable level follows its synchronized input.
- R11: Addresses 0..7 hold the channel configuration words and read back as written. Read data is valid one cycle after `rd_en`, with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_lines | input | NCH | Asynchronous external lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| rd_valid | output | 1 | High in the cycle that rdata holds read data |
| irq | output | 1 | Shared interrupt, registered |
| gate_open | output | 1 | Enable for the prescaler and counters |

## Verification
The bench targets the boundaries of the qualification window. It checks a short pulse, a line that bounces faster than the period, and the 4000 ms maximum just before and just after expiry. A design that counts a partial first tick would accept the short pulse or qualify too early. A design that does not reload on a bounce would latch an intermediate level. The bench also holds a line at its new level after clearing status and watches for a second event. It then lets an active-low line go low and masks it, and it toggles a disabled line. These expose retriggering, inverted polarity, a masked interrupt that still fires, and a clock enable that stays open with no work to do.

// File: rtl/deb_pkg.sv
package deb_pkg;
  localparam int PERIOD_W = 12;

  typedef struct packed {
    logic                mask;
    logic                en;
    logic                pol;
    logic [PERIOD_W-1:0] period;
  } chan_cfg_t;

  localparam int CFG_W      = $bits(chan_cfg_t);
  localparam int ADDR_LEVEL = 8;
  localparam int ADDR_STAT  = 9;
  localparam int ADDR_PEND  = 10;
endpackage

// File: rtl/deb_tick_gen.sv
module deb_tick_gen #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == CW'(DIV - 1));
  assign tick = run && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/deb_channel.sv
module deb_channel #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          din,
  input  logic          tick,
  input  logic          en,
  input  logic          pol,
  input  logic [PW-1:0] period,
  output logic          stable,
  output logic          event_o,
  output logic          busy
);
  logic          s1, s2, sd;
  logic [PW-1:0] cnt;
  logic          armed;
  logic [PW-1:0] load_val;

  assign load_val = (period == '0) ? PW'(1) : period;
  assign busy     = en && ((s2 != stable) || (cnt != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      sd      <= 1'b0;
      cnt     <= '0;
      armed   <= 1'b0;
      stable  <= 1'b0;
      event_o <= 1'b0;
    end else begin
      s1      <= din;
      s2      <= s1;
      sd      <= s2;
      event_o <= 1'b0;
      if (!en) begin
        cnt    <= '0;
        armed  <= 1'b0;
        stable <= s2;
      end else if (s2 != sd) begin
        cnt   <= load_val;
        armed <= 1'b0;
      end else if ((cnt != '0) && tick) begin
        if (!armed) begin
          armed <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
          if (cnt == PW'(1)) begin
            armed <= 1'b0;
            if (s2 != stable) begin
              stable  <= s2;
              event_o <= s2 ^ pol;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/deb_regfile.sv
module deb_regfile
  import deb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [NCH-1:0]      ev_vec,
  input  logic [NCH-1:0]      stab_vec,
  output logic [DW-1:0]       rdata,
  output logic                rd_valid,
  output logic                irq,
  output logic [NCH-1:0]      en_vec,
  output logic [NCH-1:0]      pol_vec,
  output logic [NCH*PERIOD_W-1:0] period_flat,
  output logic [NCH-1:0]      status_q
);
  chan_cfg_t      cfg [NCH];
  logic [NCH-1:0] mask_vec;
  logic [NCH-1:0] w1c;
  logic [NCH-1:0] pend;
  logic [DW-1:0]  rd_mux;

  for (genvar i = 0; i < NCH; i++) begin : g_cfg
    assign en_vec[i]   = cfg[i].en;
    assign pol_vec[i]  = cfg[i].pol;
    assign mask_vec[i] = cfg[i].mask;
    assign period_flat[i*PERIOD_W +: PERIOD_W] = cfg[i].period;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[i] <= '0;
      end else if (wr_en && (addr == AW'(i))) begin
        cfg[i] <= chan_cfg_t'(wdata[CFG_W-1:0]);
      end
    end
  end

  assign w1c  = (wr_en && (addr == AW'(ADDR_STAT))) ? wdata[NCH-1:0] : '0;
  assign pend = status_q & en_vec & ~mask_vec;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rd_mux = DW'(cfg[i]);
    end
    if (addr == AW'(ADDR_LEVEL)) rd_mux = DW'(stab_vec);
    if (addr == AW'(ADDR_STAT))  rd_mux = DW'(status_q);
    if (addr == AW'(ADDR_PEND))  rd_mux = DW'(pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      status_q <= (status_q & ~w1c) | (ev_vec & en_vec);
      irq      <= |pend;
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_debounce_hub.sv
module irq_debounce_hub
  import deb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DIV = 100000,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] in_lines,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           rd_valid,
  output logic           irq,
  output logic           gate_open
);
  logic [NCH-1:0]          ev_vec;
  logic [NCH-1:0]          stab_vec;
  logic [NCH-1:0]          busy_vec;
  logic [NCH-1:0]          en_vec;
  logic [NCH-1:0]          pol_vec;
  logic [NCH-1:0]          status_q;
  logic [NCH*PERIOD_W-1:0] period_flat;
  logic                    tick;

  always_ff @(posedge clk) begin
    if (rst) gate_open <= 1'b0;
    else     gate_open <= |busy_vec;
  end

  deb_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (gate_open),
    .tick (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    deb_channel #(.PW(PERIOD_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .din     (in_lines[i]),
      .tick    (tick),
      .en      (en_vec[i]),
      .pol     (pol_vec[i]),
      .period  (period_flat[i*PERIOD_W +: PERIOD_W]),
      .stable  (stab_vec[i]),
      .event_o (ev_vec[i]),
      .busy    (busy_vec[i])
    );
  end

  deb_regfile #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .ev_vec      (ev_vec),
    .stab_vec    (stab_vec),
    .rdata       (rdata),
    .rd_valid    (rd_valid),
    .irq         (irq),
    .en_vec      (en_vec),
    .pol_vec     (pol_vec),
    .period_flat (period_flat),
    .status_q    (status_q)
  );
endmodule

// File: rtl/deb_hub_checker.sv
module deb_hub_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic           tick,
  input logic           gate_open,
  input logic           irq,
  input logic [NCH-1:0] ev_vec,
  input logic [NCH-1:0] stab_vec,
  input logic [NCH-1:0] en_vec,
  input logic [NCH-1:0] status_q
);
  assert_no_status_no_irq_R6: assert property (@(posedge clk) disable iff (rst)
    !(|status_q) |=> !irq);

  assert_status_clears_by_write_R7: assert property (@(posedge clk) disable iff (rst)
    (|($past(status_q) & ~status_q)) |-> $past(wr_en));

  assert_single_event_R4: assert property (@(posedge clk) disable iff (rst)
    !(|(ev_vec & $past(ev_vec))));

  assert_event_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (|ev_vec) |-> $past(tick));

  assert_level_moves_with_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (|((stab_vec ^ $past(stab_vec)) & $past(en_vec))) |-> $past(gate_open));
endmodule

bind irq_debounce_hub deb_hub_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .tick      (tick),
  .gate_open (gate_open),
  .irq       (irq),
  .ev_vec    (ev_vec),
  .stab_vec  (stab_vec),
  .en_vec    (en_vec),
  .status_q  (status_q)
);

// File: tb/irq_debounce_hub_tb.sv
module irq_debounce_hub_tb;
  localparam int NCH = 8;
  localparam int DIV = 20;
  localparam int AW  = 4;
  localparam int DW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] in_lines = '0;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           rd_valid;
  logic           irq;
  logic           gate_open;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  irq_debounce_hub #(.NCH(NCH), .DIV(DIV), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .in_lines(in_lines), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .irq(irq), .gate_open(gate_open)
  );

  task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: compare read data as it returns
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R11: unexpected read data got=%h expected=none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic reg_write(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, input int exp, input string tag);
    @(negedge clk);
    exp_q.push_back(DW'(exp));
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    check(DW'(irq), 0, "R6 reset irq");
    check(DW'(gate_open), 0, "R9 reset gate");
    reg_read(9, 'h00, "R7 reset status");
    reg_read(8, 'h00, "R1 reset levels");

    // channel 0: active high, 3 ms
    reg_write(0, 'h2003);
    reg_read(0, 'h2003, "R11 cfg readback");
    in_lines[0] = 1'b1;
    wait_cyc(5);
    check(DW'(gate_open), 1, "R9 gate opens on change");
    // channel 5: 2 ms, early lower-bound check
    reg_write(5, 'h2002);
    in_lines[5] = 1'b1;
    wait_cyc(30);
    reg_read(8, 'h00, "R2 not qualified before period");
    wait_cyc(DIV * 4);
    reg_read(8, 'h21, "R1 R2 levels qualified");
    reg_read(9, 'h21, "R2 status set");
    check(DW'(irq), 1, "R6 irq asserted");

    // clear and hold: no retrigger
    reg_write(9, 'h21);
    wait_cyc(3);
    check(DW'(irq), 0, "R7 irq after clear");
    reg_read(9, 'h00, "R7 status cleared");
    wait_cyc(DIV * 6);
    reg_read(9, 'h00, "R4 no retrigger while held");
    check(DW'(gate_open), 0, "R9 gate closed when idle");

    // return to inactive: level updates, no event
    in_lines[0] = 1'b0;
    wait_cyc(DIV * 5);
    reg_read(8, 'h20, "R4 inactive level accepted");
    reg_read(9, 'h00, "R4 no event on inactive edge");

    // short pulse on channel 1, 1 ms
    reg_write(1, 'h2001);
    in_lines[1] = 1'b1;
    wait_cyc(15);
    in_lines[1] = 1'b0;
    wait_cyc(DIV * 4);
    reg_read(9, 'h00, "R3 short pulse status");
    reg_read(8, 'h20, "R3 short pulse level");

    // bounce on channel 2, 4 ms
    reg_write(2, 'h2004);
    for (int k = 0; k < 7; k++) begin
      in_lines[2] = ~in_lines[2];
      wait_cyc(30);
    end
    reg_read(8, 'h20, "R8 bounce keeps old level");
    wait_cyc(DIV * 6);
    reg_read(8, 'h24, "R8 settled level");
    reg_read(9, 'h04, "R8 one event after settle");
    reg_write(9, 'h04);

    // active-low channel 3
    in_lines[3] = 1'b1;
    wait_cyc(6);
    reg_write(3, 'h3002);
    reg_read(8, 'h2C, "R5 idle-high level");
    in_lines[3] = 1'b0;
    wait_cyc(DIV * 5);
    reg_read(9, 'h08, "R5 low-active event");
    check(DW'(irq), 1, "R5 irq from low-active");

    // mask channel 3
    reg_write(3, 'h7002);
    wait_cyc(3);
    check(DW'(irq), 0, "R6 masked irq low");
    reg_read(10, 'h00, "R6 pending masked");
    reg_read(9, 'h08, "R7 sticky under mask");

    // disabled channel 4
    in_lines[4] = 1'b1;
    wait_cyc(4);
    check(DW'(gate_open), 0, "R10 disabled keeps gate low");
    wait_cyc(DIV * 4);
    reg_read(9, 'h08, "R10 no event when disabled");
    reg_read(8, 'h34, "R10 level follows input");

    // maximum period on channel 6
    reg_write(6, 'h2FA0);
    in_lines[6] = 1'b1;
    wait_cyc(DIV * 3999);
    reg_read(8, 'h34, "R2 max period not yet");
    wait_cyc(100);
    reg_read(8, 'h74, "R2 max period accepted");

    wait_cyc(4);
    check(DW'(exp_q.size()), 0, "R11 all reads returned");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule